// File: doc/BRIEF.md
# Proximity card subcarrier modulator

This block produces the on/off control for the load switch of a proximity card answering a reader. It runs from a clock at the carrier rate. From that clock it derives a subcarrier at one sixteenth of the carrier and a bit period of 128 clocks, so each bit spans exactly eight subcarrier cycles. Each bit is shaped in one of four ways. Two choices set the shape: the subcarrier is either keyed on and off (ASK) or switched between two phases half a cycle apart (BPSK), and the data is either sent as plain NRZ levels or as Manchester halves.

Bits come from one of three sources. Two are built-in test streams, all ones and alternating ones and zeros. The third is an external one-bit stream with a valid/ready handshake. The block asks for each external bit in the final clock of the current bit period. A bit strobe pin marks that clock whatever source is selected. While `tx_en` is low, the block holds the switch open and parks its timing, its phase and its pattern at their starting points.

Top module: `subcarrier_modulator`

## Requirements
- R1: The bit period is 128 clocks. Within a bit, clock index t (0 to 127) has the subcarrier high for t mod 16 in 0..7 and low for 8..15. Clock 0 is the first clock after the strobe.
- R2: With ASK and NRZ, `load_sw` follows the subcarrier for the whole of a 1 bit and stays low for the whole of a 0 bit.
- R3: With ASK and Manchester, a 1 bit carries the subcarrier in clocks 0 to 63 and is silent in clocks 64 to 127. A 0 bit is the reverse.
- R4: With BPSK and NRZ, a 0 bit drives `load_sw` equal to the subcarrier (phase 0) and a 1 bit drives its inverse (phase pi). The phase changes only at bit boundaries.
- R5: With BPSK and Manchester, a 1 bit uses phase pi in clocks 0 to 63 and phase 0 in clocks 64 to 127. A 0 bit is the reverse.
- R6: `src_sel` 0 sends all ones. `src_sel` 1 sends alternating bits, starting with 1 as the first bit after enabling. `src_sel` 2 or 3 sends the external stream.
- R7: `bit_strb` is high for exactly one clock per bit period: the last clock of each bit, which is also the first enabled clock after `tx_en` rises. `in_ready` equals `bit_strb` when the external source is selected and is 0 otherwise.
- R8: A bit is taken from `in_data` at the clock edge that ends a cycle with `in_valid` and `in_ready` both high. There is no back-pressure: the producer must offer the bit in that cycle. If `in_valid` is low then, the bit sent is 0.
- R9: While `tx_en` is low, `load_sw`, `bit_strb` and `in_ready` are low in the same cycle. On re-enable, the first bit starts in phase 0 timing, and the alternating pattern restarts with 1.
- R10: During and after reset with `tx_en` low, `load_sw`, `bit_strb` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| mod_bpsk | input | 1 | 0: ASK on/off keying, 1: BPSK |
| code_manch | input | 1 | 0: NRZ, 1: Manchester |
| src_sel | input | 2 | 0 ones, 1 alternating, 2/3 external |
| in_valid | input | 1 | External bit offered |
| in_data | input | 1 | External bit value |
| in_ready | output | 1 | External bit requested this cycle |
| bit_strb | output | 1 | Last clock of the current bit period |
| load_sw | output | 1 | Load switch control |

## Verification
The bench sweeps all twelve combinations of modulation, coding and source. It compares `load_sw` every clock against a waveform the bench computes from the clock count since enabling. The all-ones stream tests each shape on a single bit value. The alternating stream exposes swapped Manchester halves and phases that fail to turn at bit boundaries. The external stream uses an irregular bit sequence, which separates a correct sampling point from one that is a bit early or late. Separate runs starve the handshake for one bit and drop `tx_en` in the middle of a bit, to show the zero fill and the restart of phase and pattern.

// File: rtl/submod_pkg.sv
package submod_pkg;
  typedef enum logic [1:0] {
    SRC_ONES = 2'd0,
    SRC_ALT  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_EXT2 = 2'd3
  } src_e;

  function automatic logic is_ext(input src_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/submod_timebase.sv
module submod_timebase #(
  parameter int SC_DIV     = 16,
  parameter int SC_PER_BIT = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    tx_en,
  output logic [$clog2(SC_DIV*SC_PER_BIT)-1:0]    cnt,
  output logic                                    last,
  output logic                                    sc,
  output logic                                    half
);
  localparam int BIT_DIV = SC_DIV * SC_PER_BIT;
  localparam int CW      = $clog2(BIT_DIV);
  localparam int SCW     = $clog2(SC_DIV);
  localparam logic [CW-1:0] LAST_V = CW'(BIT_DIV - 1);

  // Parked at the final count when idle so the first enabled clock requests a bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= LAST_V;
    else if (!tx_en) cnt <= LAST_V;
    else             cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);
  assign sc   = ~cnt[SCW-1];
  assign half = cnt[CW-1];

  a_r1_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && last) |=> (cnt == '0));
  a_r9_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> last);
endmodule

// File: rtl/submod_bitsrc.sv
module submod_bitsrc
  import submod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic last,
  input  src_e src,
  input  logic in_valid,
  input  logic in_data,
  output logic in_ready,
  output logic bit_q,
  output logic active_q
);
  logic load;
  logic alt_q;
  logic next_bit;

  assign load     = tx_en && last;
  assign in_ready = load && is_ext(src);

  always_comb begin
    unique case (src)
      SRC_ONES: next_bit = 1'b1;
      SRC_ALT:  next_bit = ~alt_q;
      default:  next_bit = in_valid & in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= 1'b0;
      active_q <= 1'b0;
      alt_q    <= 1'b0;
    end else if (!tx_en) begin
      bit_q    <= 1'b0;
      active_q <= 1'b0;
      alt_q    <= 1'b0;
    end else if (load) begin
      bit_q    <= next_bit;
      active_q <= 1'b1;
      if (src == SRC_ALT) alt_q <= ~alt_q;
    end
  end

  a_r8_take_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (bit_q == $past(in_data)));
  a_r8_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !bit_q);
  a_r6_ones_src: assert property (@(posedge clk) disable iff (!rst_n)
    (load && src == SRC_ONES) |=> bit_q);
  a_r9_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!bit_q && !active_q));
endmodule

// File: rtl/submod_shaper.sv
module submod_shaper (
  input  logic tx_en,
  input  logic active,
  input  logic mod_bpsk,
  input  logic code_manch,
  input  logic sc,
  input  logic half,
  input  logic bit_v,
  output logic sw
);
  logic level;
  logic raw;

  // Manchester: a 1 is high in the first half, low in the second.
  assign level = code_manch ? (bit_v ^ half) : bit_v;
  // BPSK: level 1 selects the inverted subcarrier; ASK: level gates it.
  assign raw   = mod_bpsk ? (sc ^ level) : (sc & level);
  assign sw    = tx_en & active & raw;
endmodule

// File: rtl/subcarrier_modulator.sv
module subcarrier_modulator
  import submod_pkg::*;
#(
  parameter int SC_DIV     = 16,
  parameter int SC_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       mod_bpsk,
  input  logic       code_manch,
  input  logic [1:0] src_sel,
  input  logic       in_valid,
  input  logic       in_data,
  output logic       in_ready,
  output logic       bit_strb,
  output logic       load_sw
);
  localparam int CW = $clog2(SC_DIV * SC_PER_BIT);

  logic [CW-1:0] cnt;
  logic last, sc, half, bit_q, active_q;
  src_e src;

  assign src = src_e'(src_sel);

  submod_timebase #(.SC_DIV(SC_DIV), .SC_PER_BIT(SC_PER_BIT)) tb_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cnt(cnt), .last(last), .sc(sc), .half(half)
  );

  submod_bitsrc src_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .last(last), .src(src),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bit_q(bit_q), .active_q(active_q)
  );

  submod_shaper shp_i (
    .tx_en(tx_en), .active(active_q), .mod_bpsk(mod_bpsk),
    .code_manch(code_manch), .sc(sc), .half(half), .bit_v(bit_q),
    .sw(load_sw)
  );

  assign bit_strb = tx_en && last;

  a_r7_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_strb);
  a_r2_ask_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_bpsk && !code_manch && !bit_q) |-> !load_sw);
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strb && tx_en && $past(tx_en)) |=> !bit_strb);
endmodule

// File: tb/subcarrier_modulator_tb_top.sv
module subcarrier_modulator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic mod_bpsk = 1'b0;
  logic code_manch = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic in_valid = 1'b0;
  logic in_data = 1'b0;
  logic in_ready, bit_strb, load_sw;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  subcarrier_modulator dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mod_bpsk(mod_bpsk),
    .code_manch(code_manch), .src_sel(src_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .bit_strb(bit_strb),
    .load_sw(load_sw)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int where);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at step %0d: actual %b expected %b", req, where, act, exp);
    end
  endtask

  function automatic logic ext_bit(input int n, input int salt);
    return ((n * 3 + salt) % 5) < 2;
  endfunction

  // One run: enable, sweep nbits bits, compare every clock, then disable.
  task automatic run_cfg(input logic mb, input logic mc, input int src,
                         input int nbits, input int starve, input int cut_at);
    string req;
    int salt = 7 * src + 2 * int'(mb) + int'(mc);
    if (!mb && !mc) req = "R2";
    else if (!mb && mc) req = "R3";
    else if (mb && !mc) req = "R4";
    else req = "R5";
    @(negedge clk);
    mod_bpsk = mb; code_manch = mc; src_sel = 2'(src);
    tx_en = 1'b1;
    for (int e = 0; e <= nbits * 128; e++) begin
      int n_req = e / 128;
      int t, n, h, b, lvl, scv, exp_sw;
      in_valid = (n_req != starve);
      in_data  = (src >= 2) ? ((n_req == starve) ? 1'b1 : ext_bit(n_req, salt)) : 1'b0;
      if (e == cut_at) begin
        tx_en = 1'b0;
        #1;
        chk("R9", load_sw, 1'b0, e);
        chk("R9", bit_strb, 1'b0, e);
        chk("R9", in_ready, 1'b0, e);
        break;
      end
      #1;
      if (e == 0) exp_sw = 0;
      else begin
        t = e - 1;
        n = t / 128;
        h = (t / 64) % 2;
        if (src == 0) b = 1;
        else if (src == 1) b = (n % 2 == 0) ? 1 : 0;
        else b = (n == starve) ? 0 : int'(ext_bit(n, salt));
        lvl = mc ? (b ^ h) : b;
        scv = ((t % 16) < 8) ? 1 : 0;
        exp_sw = mb ? (scv ^ lvl) : (scv & lvl);
      end
      if (src == 1) chk({req, "/R6"}, load_sw, exp_sw[0], e);
      else if (src >= 2) chk({req, "/R8"}, load_sw, exp_sw[0], e);
      else chk({req, "/R1"}, load_sw, exp_sw[0], e);
      chk("R7", bit_strb, (e % 128) == 0, e);
      chk("R7", in_ready, ((e % 128) == 0) && (src >= 2), e);
      @(negedge clk);
    end
    tx_en = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9", load_sw, 1'b0, k);
      chk("R9", bit_strb, 1'b0, k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", load_sw, 1'b0, 0);
    chk("R10", bit_strb, 1'b0, 0);
    chk("R10", in_ready, 1'b0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", load_sw, 1'b0, 1);
    chk("R10", bit_strb, 1'b0, 1);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 4; s++)
          if (s != 3) run_cfg(m[0], c[0], s, 4, -1, -1);
    run_cfg(1'b0, 1'b0, 3, 4, 2, -1);      // R8: starved third bit sends zero
    run_cfg(1'b1, 1'b1, 2, 4, 1, -1);      // R8 with Manchester BPSK
    run_cfg(1'b1, 1'b0, 1, 4, -1, 200);    // R9: cut mid-bit
    run_cfg(1'b1, 1'b0, 1, 3, -1, -1);     // R9: alternating restarts with 1
    run_cfg(1'b0, 1'b1, 1, 2, -1, 90);     // R9: cut in first bit
    run_cfg(1'b0, 1'b1, 1, 3, -1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule